// File: doc/BRIEF.md
# Write-First Dual-Port Synchronous RAM

A single-clock memory with two symmetric ports, A and B. Each port has its own address, write strobe, write data and registered read data. One clock-enable gates both ports. On an enabled edge each port either writes its data or reads, and the read register of each port is loaded at that same edge. Read data therefore appears one cycle after the address is presented.

Read-during-write always returns the new value. A port that writes sees its own write data on its read output in the next cycle. A port that reads the address the other port is writing in the same cycle also gets that write data. If both ports write one address in the same cycle, the result is formally undefined. This implementation lets port B win, both in the stored cell and on both outputs. Depth is two to the power of the address width, so every address value names a real cell.

The ports are plain and have no handshake. Every enabled cycle is accepted and there is no back-pressure. Address width and data width are parameters.

Top module: `wf_tdpram`

## Requirements
- R1: While `en` is low, no cell is written and both `rdata_a` and `rdata_b` keep their values, whatever the other inputs do.
- R2: On an enabled edge where a port does not write and the other port does not write its address, that port's read output in the next cycle equals the stored content of its address.
- R3: A write on an enabled edge updates the cell, and a later read of that address from either port returns the written value.
- R4: When a port writes on an enabled edge, its own read output in the next cycle equals the data it wrote (write-first). This holds unless port A collides with a port B write, where R8 applies.
- R5: When port B writes an address that port A reads on the same enabled edge, `rdata_a` in the next cycle equals `wdata_b`.
- R6: When port A writes an address that port B reads on the same enabled edge, `rdata_b` in the next cycle equals `wdata_a`.
- R7: Both ports may write different addresses on the same edge. Both cells are updated, and each port outputs its own write data.
- R8: When both ports write the same address on one edge, port B takes priority: the cell holds `wdata_b` and both outputs show `wdata_b` in the next cycle. A later write to that cell restores defined content.
- R9: The memory has 2**AW cells, and the lowest and highest addresses are distinct, usable cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| en | input | 1 | Clock-enable for both ports |
| wr_a | input | 1 | Write strobe, port A |
| wr_b | input | 1 | Write strobe, port B |
| addr_a | input | AW | Address, port A |
| addr_b | input | AW | Address, port B |
| wdata_a | input | DW | Write data, port A |
| wdata_b | input | DW | Write data, port B |
| rdata_a | output | DW | Registered read data, port A |
| rdata_b | output | DW | Registered read data, port B |

## Verification
The hardest case to reach from the ports is a cross-port hit. It needs both ports on the same address in the same enabled cycle, with exactly one of them writing, and uniformly random addresses rarely produce it. The stimulus therefore draws half of its addresses from a pool of four values, so that same-address pairs, collisions and cross-port forwarding occur many times. It also interleaves disabled cycles that carry live write strobes. The bench does not check dual-write collisions directly. It marks the cell unknown and resumes checking once a later write defines the cell again.

// File: rtl/wf_tdpram_pkg.sv
package wf_tdpram_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_RD_BOTH = 3'd1,
    CMD_WR_A    = 3'd2,
    CMD_WR_B    = 3'd3,
    CMD_WR_BOTH = 3'd4
  } tdp_cmd_e;

  function automatic tdp_cmd_e decode_cmd(input logic en, input logic wa, input logic wb);
    if (!en)            return CMD_IDLE;
    else if (wa && wb)  return CMD_WR_BOTH;
    else if (wa)        return CMD_WR_A;
    else if (wb)        return CMD_WR_B;
    else                return CMD_RD_BOTH;
  endfunction

  function automatic logic cmd_writes_a(input tdp_cmd_e c);
    return (c == CMD_WR_A) || (c == CMD_WR_BOTH);
  endfunction

  function automatic logic cmd_writes_b(input tdp_cmd_e c);
    return (c == CMD_WR_B) || (c == CMD_WR_BOTH);
  endfunction

endpackage

// File: rtl/wf_tdpram_store.sv
module wf_tdpram_store #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wen_a,
  input  logic          wen_b,
  input  logic [AW-1:0] waddr_a,
  input  logic [AW-1:0] waddr_b,
  input  logic [DW-1:0] wd_a,
  input  logic [DW-1:0] wd_b,
  output logic [DW-1:0] cell_a,
  output logic [DW-1:0] cell_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // Port B is written last, so it wins a same-address collision.
  always_ff @(posedge clk) begin
    if (wen_a) cells[waddr_a] <= wd_a;
    if (wen_b) cells[waddr_b] <= wd_b;
  end

  // Unregistered look-up; the read registers live in the top.
  assign cell_a = cells[waddr_a];
  assign cell_b = cells[waddr_b];
endmodule

// File: rtl/wf_tdpram_rdsel.sv
module wf_tdpram_rdsel #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter bit OTHER_WINS = 1'b0
) (
  input  logic          own_wr,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] own_wd,
  input  logic          oth_wr,
  input  logic [AW-1:0] oth_addr,
  input  logic [DW-1:0] oth_wd,
  input  logic [DW-1:0] cell_q,
  output logic [DW-1:0] next_q
);
  logic hit;
  assign hit = oth_wr && (own_addr == oth_addr);

  always_comb begin
    if (hit && (!own_wr || OTHER_WINS)) next_q = oth_wd;
    else if (own_wr)                    next_q = own_wd;
    else                                next_q = cell_q;
  end
endmodule

// File: rtl/wf_tdpram.sv
module wf_tdpram
  import wf_tdpram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_a,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  localparam int NPORT = 2;

  tdp_cmd_e cmd;
  logic     wen_a, wen_b;

  assign cmd   = decode_cmd(en, wr_a, wr_b);
  assign wen_a = cmd_writes_a(cmd);
  assign wen_b = cmd_writes_b(cmd);

  logic [DW-1:0] cell_a, cell_b;

  wf_tdpram_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .wen_a   (wen_a),
    .wen_b   (wen_b),
    .waddr_a (addr_a),
    .waddr_b (addr_b),
    .wd_a    (wdata_a),
    .wd_b    (wdata_b),
    .cell_a  (cell_a),
    .cell_b  (cell_b)
  );

  logic          p_wr   [NPORT];
  logic [AW-1:0] p_addr [NPORT];
  logic [DW-1:0] p_wd   [NPORT];
  logic [DW-1:0] p_cell [NPORT];
  logic [DW-1:0] p_next [NPORT];
  logic [DW-1:0] p_q    [NPORT];

  assign p_wr[0]   = wen_a;   assign p_wr[1]   = wen_b;
  assign p_addr[0] = addr_a;  assign p_addr[1] = addr_b;
  assign p_wd[0]   = wdata_a; assign p_wd[1]   = wdata_b;
  assign p_cell[0] = cell_a;  assign p_cell[1] = cell_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    // Port A (index 0) yields to port B on a dual write.
    wf_tdpram_rdsel #(.AW(AW), .DW(DW), .OTHER_WINS(p == 0)) u_rdsel (
      .own_wr   (p_wr[p]),
      .own_addr (p_addr[p]),
      .own_wd   (p_wd[p]),
      .oth_wr   (p_wr[NPORT-1-p]),
      .oth_addr (p_addr[NPORT-1-p]),
      .oth_wd   (p_wd[NPORT-1-p]),
      .cell_q   (p_cell[p]),
      .next_q   (p_next[p])
    );

    always_ff @(posedge clk) begin
      if (en) p_q[p] <= p_next[p];
    end
  end

  assign rdata_a = p_q[0];
  assign rdata_b = p_q[1];
endmodule

// File: rtl/wf_tdpram_chk.sv
module wf_tdpram_chk #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          en,
  input logic          wr_a,
  input logic          wr_b,
  input logic [AW-1:0] addr_a,
  input logic [AW-1:0] addr_b,
  input logic [DW-1:0] wdata_a,
  input logic [DW-1:0] wdata_b,
  input logic [DW-1:0] rdata_a,
  input logic [DW-1:0] rdata_b
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  logic same;
  assign same = (addr_a == addr_b);

  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!primed)
    !en |=> ($stable(rdata_a) && $stable(rdata_b)));

  assert_same_addr_reads_agree_R2: assert property (@(posedge clk) disable iff (!primed)
    (en && !wr_a && !wr_b && same) |=> (rdata_a == rdata_b));

  assert_own_write_first_a_R4: assert property (@(posedge clk) disable iff (!primed)
    (en && wr_a && !(wr_b && same)) |=> (rdata_a == $past(wdata_a)));

  assert_own_write_first_b_R4: assert property (@(posedge clk) disable iff (!primed)
    (en && wr_b) |=> (rdata_b == $past(wdata_b)));

  assert_fwd_b_to_a_R5: assert property (@(posedge clk) disable iff (!primed)
    (en && wr_b && !wr_a && same) |=> (rdata_a == $past(wdata_b)));

  assert_fwd_a_to_b_R6: assert property (@(posedge clk) disable iff (!primed)
    (en && wr_a && !wr_b && same) |=> (rdata_b == $past(wdata_a)));

  assert_dual_write_b_wins_R8: assert property (@(posedge clk) disable iff (!primed)
    (en && wr_a && wr_b && same) |=> (rdata_a == $past(wdata_b)));
endmodule

bind wf_tdpram wf_tdpram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .en(en), .wr_a(wr_a), .wr_b(wr_b),
  .addr_a(addr_a), .addr_b(addr_b), .wdata_a(wdata_a), .wdata_b(wdata_b),
  .rdata_a(rdata_a), .rdata_b(rdata_b)
);

// File: tb/wf_tdpram_test.sv
module wf_tdpram_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          en = 1'b0, wr_a = 1'b0, wr_b = 1'b0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [DW-1:0] wdata_a = '0, wdata_b = '0;
  logic [DW-1:0] rdata_a, rdata_b;

  always #2 clk = ~clk;

  wf_tdpram #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .en(en), .wr_a(wr_a), .wr_b(wr_b),
    .addr_a(addr_a), .addr_b(addr_b), .wdata_a(wdata_a), .wdata_b(wdata_b),
    .rdata_a(rdata_a), .rdata_b(rdata_b)
  );

  typedef struct {
    bit            chk_a, chk_b;
    logic [DW-1:0] exp_a, exp_b;
    string         tag_a, tag_b;
  } item_t;

  item_t         sb[$];
  logic [DW-1:0] ref_mem [DEPTH];
  bit            known   [DEPTH];
  logic [DW-1:0] cur_a = '0, cur_b = '0;
  bit            ok_a = 1'b0, ok_b = 1'b0;
  int            total = 0, bad = 0;
  bit            finished = 1'b0;

  task automatic check(string tag, string port, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s port %s actual=%h expected=%h", tag, port, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic drive(bit e, bit wa, bit wb, logic [AW-1:0] aa, logic [AW-1:0] ab,
                       logic [DW-1:0] da, logic [DW-1:0] db, string force_tag = "");
    item_t it;
    bit coll;
    @(negedge clk);
    en = e; wr_a = wa; wr_b = wb; addr_a = aa; addr_b = ab; wdata_a = da; wdata_b = db;
    coll = wa && wb && (aa == ab);
    if (!e) begin
      it.tag_a = "R1"; it.tag_b = "R1";
    end else begin
      if (coll)                   begin ok_a = 0; it.tag_a = "R8"; end
      else if (wa)                begin cur_a = da; ok_a = 1; it.tag_a = "R4"; end
      else if (wb && ab == aa)    begin cur_a = db; ok_a = 1; it.tag_a = "R5"; end
      else                        begin cur_a = ref_mem[aa]; ok_a = known[aa]; it.tag_a = "R2"; end
      if (coll)                   begin ok_b = 0; it.tag_b = "R8"; end
      else if (wb)                begin cur_b = db; ok_b = 1; it.tag_b = "R4"; end
      else if (wa && aa == ab)    begin cur_b = da; ok_b = 1; it.tag_b = "R6"; end
      else                        begin cur_b = ref_mem[ab]; ok_b = known[ab]; it.tag_b = "R2"; end
      if (coll) known[aa] = 0;
      else begin
        if (wa) begin ref_mem[aa] = da; known[aa] = 1; end
        if (wb) begin ref_mem[ab] = db; known[ab] = 1; end
      end
    end
    if (force_tag != "") begin it.tag_a = force_tag; it.tag_b = force_tag; end
    it.chk_a = ok_a; it.chk_b = ok_b; it.exp_a = cur_a; it.exp_b = cur_b;
    sb.push_back(it);
  endtask

  // Monitor: compares one queued item per clock, after the edge settles.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.chk_a) check(it.tag_a, "A", rdata_a, it.exp_a);
      if (it.chk_b) check(it.tag_b, "B", rdata_b, it.exp_b);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  function automatic logic [AW-1:0] pick_addr();
    if ($urandom_range(1, 0) == 0) return AW'($urandom_range(3, 0));
    return AW'($urandom);
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin known[i] = 0; ref_mem[i] = '0; end
    // Fill: two different addresses per cycle (R7, R9 covers top and bottom).
    for (int i = 0; i < DEPTH; i += 2)
      drive(1, 1, 1, AW'(i), AW'(i + 1), DW'(16'h1000 + i), DW'(16'h2000 + i), "R7");
    // Read back every cell from both ports (R3, R9).
    for (int i = 0; i < DEPTH; i++)
      drive(1, 0, 0, AW'(i), AW'(DEPTH - 1 - i), '0, '0, (i == 0) ? "R9" : "R3");
    // Idle with live strobes, then confirm no write happened (R1).
    drive(0, 1, 1, AW'(5), AW'(6), 16'hdead, 16'hbeef);
    drive(0, 0, 0, '0, '0, '0, '0);
    drive(1, 0, 0, AW'(5), AW'(6), '0, '0, "R1");
    // Same-port write-first (R4).
    drive(1, 1, 0, AW'(9), AW'(10), 16'h4a4a, '0);
    // Cross-port forwarding both directions (R5, R6).
    drive(1, 0, 1, AW'(12), AW'(12), '0, 16'h5b5b);
    drive(1, 1, 0, AW'(13), AW'(13), 16'h6c6c, '0);
    // Dual-write collision, then rewrite and read back (R8).
    drive(1, 1, 1, AW'(20), AW'(20), 16'h7777, 16'h8888);
    drive(1, 1, 0, AW'(20), AW'(21), 16'h9999, '0);
    drive(1, 0, 0, AW'(21), AW'(20), '0, '0, "R8");
    // Randomised traffic biased toward collisions.
    for (int n = 0; n < 4000; n++)
      drive($urandom_range(99, 0) < 85, $urandom_range(1, 0) == 1, $urandom_range(1, 0) == 1,
            pick_addr(), pick_addr(), DW'($urandom), DW'($urandom));
    drive(0, 0, 0, '0, '0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule